// File: doc/BRIEF.md
# Converter Capture and Sleep Sequencer

This block sits beside an 8-bit pipelined sampling converter. It runs the converter's encode clock from the system clock through a programmable divider and drives the active-high power-down line. It captures the parallel word the converter returns and converts it from offset binary to two's complement. A sample is offered on a one-cycle valid/data stream only when it can be trusted. A word is trusted only when the converter was powered, had settled after waking, and had flushed its four-stage pipeline.

Software or a controlling state machine raises `run` to start conversion and raises `sleep_req` (or drops `run`) to put the converter to sleep. Each wake-up blanks the first 19 encode periods: 15 for settling and 4 for pipeline latency. Entry into sleep is only taken at the end of an encode period. The `busy` output covers the two encode periods the converter needs to reach its low-power state. After that, `asleep` is reported and encoding stops. A 16-bit count reports how many valid words have been delivered since the last wake-up.

Top module: `adc_capture_seq`

## Requirements
- R1: While `rst` is high and after it is released, `adc_pd`=1, `asleep`=1, `busy`=0, `adc_enc`=0, `out_valid`=0 and `sample_cnt`=0. Nothing changes until a wake-up is accepted.
- R2: A wake-up is accepted on a clock edge where `run`=1, `sleep_req`=0 and `div_sel` is legal. From the next cycle the encode period is `div_sel` system clocks. `adc_enc` is high for the first floor(`div_sel`/2) cycles of each period, starting with the first cycle after acceptance.
- R3: A legal `div_sel` lies in 2..CLK_MHZ/MIN_MHZ, which is 2..100 by default. `cfg_err` is 1 whenever `div_sel` is outside that range, and a wake-up is then refused.
- R4: The bus is captured in phase floor(P/2) of each encode period. Periods are numbered from 0 after a wake-up, and the captures of periods 0..18 are never marked valid.
- R5: From period 19 on, while running, each capture gives `out_valid`=1 for exactly one cycle, on the cycle after the capture.
- R6: `out_data` is the captured code minus 128 as two's complement, which means the top bit is inverted. So 0x00 gives 0x80, 0x7F gives 0xFF, 0x80 gives 0x00 and 0xFF gives 0x7F.
- R7: A sleep request (`sleep_req`=1 or `run`=0) is acted on only in the last cycle of an encode period. `adc_pd` rises at the start of the next period. No word captured while `adc_pd`=1 is delivered.
- R8: `busy`=1 for exactly two encode periods after `adc_pd` rises. Then encoding stops and `asleep`=1.
- R9: `sample_cnt` clears on each accepted wake-up, adds one with each valid word, and wraps from 65535 to 0.
- R10: Changing `div_sel` while the converter is awake or entering sleep has no effect. The period latched at wake-up is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Conversion enable |
| sleep_req | input | 1 | Request to power the converter down |
| div_sel | input | 8 | Encode period in system clocks |
| adc_data | input | 8 | Offset-binary word from the converter |
| adc_enc | output | 1 | Encode clock to the converter |
| adc_pd | output | 1 | Power-down line to the converter, high = sleep |
| out_valid | output | 1 | One-cycle strobe for a trusted sample |
| out_data | output | 8 | Two's complement sample |
| busy | output | 1 | Power-down entry in progress |
| asleep | output | 1 | Converter powered down, encode stopped |
| cfg_err | output | 1 | `div_sel` is outside the legal range |
| sample_cnt | output | 16 | Valid words since the last wake-up |

## Verification
The bench goes after the blanking boundary. A design that counts the pipeline delay but not the settling interval, or that counts one period short, delivers its first word in the wrong period, and the per-cycle model flags that period. It drives a divider of 2, where capture and period end fall in the same cycle, and odd dividers, where an off-by-one in the high-time or capture phase shows up on `adc_enc` and `out_data`. It places sleep requests mid-period and changes `div_sel` while awake. A design that acts on requests at once or re-reads the divider shifts `adc_pd`, `busy` or the period. It also runs more than 65536 words at the fastest divider to catch a count that saturates instead of wrapping.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    ST_DOWN   = 2'd0,
    ST_WAKE   = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_ENTER  = 2'd3
  } seq_state_t;

  // legal encode period: at least two clocks (one high, one low) and no
  // longer than the period that keeps the encode rate at its minimum
  function automatic logic div_ok(input int unsigned d, input int unsigned maxd);
    return (d >= 2) && (d <= maxd);
  endfunction

  function automatic int unsigned blank_periods(input int unsigned pipe,
                                                input int unsigned settle);
    return pipe + settle;
  endfunction

endpackage

// File: rtl/adcseq_clkdiv.sv
module adcseq_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [DIV_W-1:0] div,
  output logic             enc,
  output logic             cap_pulse,
  output logic             end_pulse
);

  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] half;

  assign half      = div >> 1;
  assign end_pulse = run_en && (phase == div - DIV_W'(1));
  assign cap_pulse = run_en && (phase == half);
  assign enc       = run_en && (phase < half);

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      phase <= '0;
    end else if (end_pulse) begin
      phase <= '0;
    end else begin
      phase <= phase + DIV_W'(1);
    end
  end

  // R2: the phase counter never leaves the latched period
  a_r2_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    run_en |-> (phase < div));

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int MAX_DIV   = 100,
  parameter int PIPE_LAT  = 4,
  parameter int SETTLE    = 15,
  parameter int ENTRY_PER = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sleep_req,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cap_pulse,
  input  logic             end_pulse,
  output logic             encoding,
  output logic [DIV_W-1:0] div_q,
  output logic             pd,
  output logic             busy,
  output logic             asleep,
  output logic             accept,
  output logic             wake,
  output logic             cfg_ok
);

  localparam int BLANK = blank_periods(PIPE_LAT, SETTLE);
  localparam int BLK_W = $clog2(BLANK + 1);
  localparam int ENT_W = $clog2(ENTRY_PER + 1);

  seq_state_t       state;
  logic [BLK_W-1:0] blank_left;
  logic [ENT_W-1:0] entry_left;
  logic             stop_req;

  assign cfg_ok   = div_ok(32'(cfg_div), MAX_DIV);
  assign stop_req = sleep_req || !run;
  assign wake     = (state == ST_DOWN) && run && !sleep_req && cfg_ok;
  assign encoding = (state != ST_DOWN);
  assign pd       = (state == ST_DOWN) || (state == ST_ENTER);
  assign busy     = (state == ST_ENTER);
  assign asleep   = (state == ST_DOWN);
  assign accept   = cap_pulse && (state == ST_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_DOWN;
      div_q      <= DIV_W'(2);
      blank_left <= '0;
      entry_left <= '0;
    end else begin
      unique case (state)
        ST_DOWN: begin
          if (wake) begin
            state      <= ST_WAKE;
            div_q      <= cfg_div;
            blank_left <= BLK_W'(BLANK);
          end
        end
        ST_WAKE: begin
          if (cap_pulse) begin
            blank_left <= blank_left - BLK_W'(1);
            if (blank_left == BLK_W'(1)) state <= ST_ACTIVE;
          end
          // a request at the period end overrides the blanking exit
          if (end_pulse && stop_req) begin
            state      <= ST_ENTER;
            entry_left <= ENT_W'(ENTRY_PER);
          end
        end
        ST_ACTIVE: begin
          if (end_pulse && stop_req) begin
            state      <= ST_ENTER;
            entry_left <= ENT_W'(ENTRY_PER);
          end
        end
        ST_ENTER: begin
          if (end_pulse) begin
            if (entry_left == ENT_W'(1)) state <= ST_DOWN;
            else entry_left <= entry_left - ENT_W'(1);
          end
        end
        default: state <= ST_DOWN;
      endcase
    end
  end

  // R3: leaving sleep only ever follows a legal divider setting
  a_r3_wake_legal: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep) |-> $past(cfg_ok));

  // R7: sleep entry begins only after a period boundary
  a_r7_entry_on_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(end_pulse));

  // R8: entry always holds the converter in power-down
  a_r8_busy_powered_down: assert property (@(posedge clk) disable iff (rst)
    busy |-> pd);

  // R10: the period is frozen for the whole awake interval
  a_r10_div_frozen: assert property (@(posedge clk) disable iff (rst)
    ($past(!asleep) && !asleep) |-> $stable(div_q));

endmodule

// File: rtl/adcseq_capture.sv
module adcseq_capture #(
  parameter int DW    = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             wake,
  input  logic [DW-1:0]    adc_data,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic [CNT_W-1:0] sample_cnt
);

  // offset binary to two's complement: flip the sign position
  function automatic logic [DW-1:0] ob_to_tc(input logic [DW-1:0] w);
    return {~w[DW-1], w[DW-2:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      sample_cnt <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_data   <= ob_to_tc(adc_data);
        sample_cnt <= sample_cnt + CNT_W'(1);
      end else if (wake) begin
        sample_cnt <= '0;
      end
    end
  end

  // R5: a delivered word is a single-cycle strobe
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R9: each delivered word advances the count by exactly one, modulo 2^CNT_W
  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (sample_cnt == CNT_W'($past(sample_cnt) + CNT_W'(1))));

endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq #(
  parameter int CLK_MHZ   = 100,
  parameter int MIN_MHZ   = 1,
  parameter int DW        = 8,
  parameter int DIV_W     = 8,
  parameter int CNT_W     = 16,
  parameter int PIPE_LAT  = 4,
  parameter int SETTLE    = 15,
  parameter int ENTRY_PER = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sleep_req,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [DW-1:0]    adc_data,
  output logic             adc_enc,
  output logic             adc_pd,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             busy,
  output logic             asleep,
  output logic             cfg_err,
  output logic [CNT_W-1:0] sample_cnt
);

  localparam int MAX_DIV = CLK_MHZ / MIN_MHZ;

  logic             encoding;
  logic [DIV_W-1:0] div_q;
  logic             cap_pulse;
  logic             end_pulse;
  logic             accept;
  logic             wake;
  logic             cfg_ok;

  adcseq_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .run_en    (encoding),
    .div       (div_q),
    .enc       (adc_enc),
    .cap_pulse (cap_pulse),
    .end_pulse (end_pulse)
  );

  adcseq_ctrl #(
    .DIV_W     (DIV_W),
    .MAX_DIV   (MAX_DIV),
    .PIPE_LAT  (PIPE_LAT),
    .SETTLE    (SETTLE),
    .ENTRY_PER (ENTRY_PER)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .sleep_req (sleep_req),
    .cfg_div   (div_sel),
    .cap_pulse (cap_pulse),
    .end_pulse (end_pulse),
    .encoding  (encoding),
    .div_q     (div_q),
    .pd        (adc_pd),
    .busy      (busy),
    .asleep    (asleep),
    .accept    (accept),
    .wake      (wake),
    .cfg_ok    (cfg_ok)
  );

  adcseq_capture #(.DW(DW), .CNT_W(CNT_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .wake       (wake),
    .adc_data   (adc_data),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .sample_cnt (sample_cnt)
  );

  assign cfg_err = !cfg_ok;

  // R1: while asleep the converter is held down and not clocked
  a_r1_asleep_quiet: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (adc_pd && !adc_enc && !busy));

  // R7: no word is delivered from a capture taken during power-down
  a_r7_no_word_from_pd: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$past(adc_pd));

endmodule

// File: tb/tb_adc_capture_seq.sv
module tb_adc_capture_seq;

  localparam int CLK_P    = 10;
  localparam int MAXD     = 100;
  localparam int WDOG_CYC = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        sleep_req = 1'b0;
  logic [7:0]  div_sel = 8'd4;
  logic [7:0]  adc_data = 8'd0;
  logic        adc_enc, adc_pd, out_valid, busy, asleep, cfg_err;
  logic [7:0]  out_data;
  logic [15:0] sample_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit fixed_en = 1'b0;
  logic [7:0] fixed_val = 8'd0;
  int valids_seen = 0;

  // behavioural model state
  int m_mode = 0;          // 0 asleep, 1 running, 2 entering sleep
  int m_t = 0;
  int m_P = 2;
  int m_ek = 0;
  int unsigned m_cnt = 0;
  bit m_val = 1'b0;
  logic [7:0] m_dat = 8'd0;

  adc_capture_seq dut (
    .clk(clk), .rst(rst), .run(run), .sleep_req(sleep_req), .div_sel(div_sel),
    .adc_data(adc_data), .adc_enc(adc_enc), .adc_pd(adc_pd),
    .out_valid(out_valid), .out_data(out_data), .busy(busy), .asleep(asleep),
    .cfg_err(cfg_err), .sample_cnt(sample_cnt)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic bit legal(input int d);
    return d >= 2 && d <= MAXD;
  endfunction

  // converter bus: a scrambled sweep unless a fixed code is forced
  always @(negedge clk) adc_data <= fixed_en ? fixed_val : 8'((cyc * 37 + 11) & 255);

  // model step at the edge, comparison a quarter period later
  always @(posedge clk) begin
    int k, ph;
    cyc++;
    m_val = 1'b0;
    if (rst) begin
      m_mode = 0; m_cnt = 0;
    end else begin
      case (m_mode)
        0: if (run && !sleep_req && legal(div_sel)) begin
             m_mode = 1; m_P = div_sel; m_t = 0; m_cnt = 0;
           end
        1: begin
             k = m_t / m_P; ph = m_t % m_P;
             if (ph == m_P / 2 && k >= 19) begin
               m_val = 1'b1;
               m_dat = 8'(int'(adc_data) - 128);
               m_cnt = (m_cnt + 1) % 65536;
             end
             if (ph == m_P - 1 && (sleep_req || !run)) begin
               m_mode = 2; m_ek = k + 1;
             end
             m_t++;
           end
        default: begin
             k = m_t / m_P; ph = m_t % m_P;
             if (ph == m_P - 1 && k == m_ek + 1) m_mode = 0;
             m_t++;
           end
      endcase
    end
    #(CLK_P/4);
    if (out_valid) valids_seen++;
    chk(adc_enc === (m_mode != 0 && (m_t % m_P) < m_P / 2), "R2 adc_enc", int'(adc_enc),
        int'(m_mode != 0 && (m_t % m_P) < m_P / 2));
    chk(adc_pd === (m_mode != 1), "R7 adc_pd", int'(adc_pd), int'(m_mode != 1));
    chk(busy === (m_mode == 2), "R8 busy", int'(busy), int'(m_mode == 2));
    chk(asleep === (m_mode == 0), "R8 asleep", int'(asleep), int'(m_mode == 0));
    chk(out_valid === m_val, "R4/R5 out_valid", int'(out_valid), int'(m_val));
    if (m_val) chk(out_data === m_dat, "R6 out_data", int'(out_data), int'(m_dat));
    chk(int'(sample_cnt) == int'(m_cnt), "R9 sample_cnt", int'(sample_cnt), int'(m_cnt));
    chk(cfg_err === !legal(div_sel), "R3 cfg_err", int'(cfg_err), int'(!legal(div_sel)));
    if (cyc > WDOG_CYC) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected below %0d", cyc, WDOG_CYC);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic at_q();
    @(posedge clk); #(CLK_P/4);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_asleep();
    while (!asleep) at_q();
  endtask

  task automatic code_check(input logic [7:0] code, input logic [7:0] exp);
    @(negedge clk); fixed_en = 1'b1; fixed_val = code;
    at_q(); while (!out_valid) at_q();
    at_q(); while (!out_valid) at_q();
    chk(out_data === exp, "R6 corner code", int'(out_data), int'(exp));
  endtask

  initial begin
    int rises, bcount, start_seen;
    cycles(3);
    at_q();
    chk(adc_pd && asleep && !busy && !out_valid && !adc_enc && sample_cnt == 0,
        "R1 reset state", int'(adc_pd), 1);
    @(negedge clk); rst = 1'b0;
    at_q();
    chk(adc_pd && asleep && !adc_enc, "R1 after release", int'(asleep), 1);

    // illegal dividers refuse wake-up
    @(negedge clk); div_sel = 8'd1; run = 1'b1;
    cycles(20); at_q();
    chk(asleep === 1'b1 && cfg_err === 1'b1, "R3 divider 1 refused", int'(asleep), 1);
    @(negedge clk); div_sel = 8'd101;
    cycles(20); at_q();
    chk(asleep === 1'b1 && cfg_err === 1'b1, "R3 divider 101 refused", int'(asleep), 1);

    // wake with period 4, count encode rises before the first word
    @(negedge clk); div_sel = 8'd4;
    at_q(); while (asleep) at_q();
    rises = adc_enc ? 1 : 0;
    start_seen = 0;
    while (!out_valid) begin
      logic pe;
      pe = adc_enc;
      at_q();
      if (adc_enc && !pe) rises++;
    end
    chk(rises == 20, "R4 first word after 19 blanked periods", rises, 20);
    chk(sample_cnt == 16'd1, "R9 first count", int'(sample_cnt), 1);

    code_check(8'h00, 8'h80);
    code_check(8'h7F, 8'hFF);
    code_check(8'h80, 8'h00);
    code_check(8'hFF, 8'h7F);
    @(negedge clk); fixed_en = 1'b0;

    // divider change while awake is ignored (model keeps period 4)
    @(negedge clk); div_sel = 8'd9;
    cycles(60);

    // sleep request in mid-period, measure busy length
    cycles(2);
    @(negedge clk); sleep_req = 1'b1;
    at_q(); while (!busy) at_q();
    bcount = 0;
    while (busy) begin bcount++; at_q(); end
    chk(bcount == 8, "R8 busy spans two periods of 4", bcount, 8);
    chk(asleep === 1'b1, "R8 asleep after entry", int'(asleep), 1);

    // wake again with odd period 9, count clears
    @(negedge clk); sleep_req = 1'b0;
    at_q(); while (asleep) at_q();
    at_q();
    chk(sample_cnt == 16'd0, "R9 count cleared on wake", int'(sample_cnt), 0);
    cycles(300);
    @(negedge clk); run = 1'b0;
    wait_asleep();

    // odd period 3, then reset mid-run
    @(negedge clk); div_sel = 8'd3; run = 1'b1;
    cycles(150);
    @(negedge clk); rst = 1'b1;
    at_q();
    chk(adc_pd && asleep && !out_valid && sample_cnt == 0, "R1 reset while running",
        int'(sample_cnt), 0);
    @(negedge clk); rst = 1'b0; run = 1'b0;
    cycles(3);

    // longest legal period
    @(negedge clk); div_sel = 8'd100; run = 1'b1;
    cycles(2300);
    @(negedge clk); run = 1'b0;
    wait_asleep();

    // fastest period, beyond the count wrap
    @(negedge clk); div_sel = 8'd2; run = 1'b1;
    valids_seen = 0;
    cycles(2 * (65536 + 19 + 6));
    at_q();
    chk(valids_seen > 65536, "R9 enough words for wrap", valids_seen, 65537);
    chk(int'(sample_cnt) == valids_seen % 65536, "R9 wrap at 2^16", int'(sample_cnt),
        valids_seen % 65536);
    @(negedge clk); run = 1'b0;
    wait_asleep();
    cycles(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule